// File: doc/BRIEF.md
# Write-Through Set-Associative Data Cache

This block is a level-one data cache between a processor's load/store port and a next-level memory. Each request address is split into a tag, a set index and a byte offset. The tags of every way in the indexed set are compared in parallel, and a load that hits returns its word one cycle after it is accepted. A load that misses picks a victim way in its set and fetches the whole line, one 32-bit beat per cycle, starting from word 0. The load's response is released on the cycle the addressed word arrives.

Stores are write-through: each one becomes exactly one word write on the next-level write channel. A store that hits also updates the cached copy. A store that misses leaves the cache contents untouched.

A back-invalidate input lets an inclusive outer cache force out a line when the outer cache evicts its own copy. The capacity, the number of ways and the line size are elaboration-time parameters, each a power of two. At least two ways are required.

Top module: `wt_dcache`

## Requirements
- R1: With the default parameters (32768 bytes, 4 ways, 128-byte lines), the set index is (addr & 0x1FFF) >> 7 and the tag is addr >> 13. For example, address 0xDEADBEEF uses set 0x3D and requests the fill at line address 0xDEADBE80.
- R2: A load that hits raises rsp_valid for one cycle, in the cycle after acceptance. rsp_rdata carries the stored word at addr & ~3, and no fill is requested.
- R3: A load that misses makes exactly one fill request with a line-aligned address. fill_req_valid and fill_req_addr stay steady until fill_req_ready. The line then arrives as beats in word order 0 to last, one beat per cycle in which fill_rvalid is high.
- R4: For a load miss, rsp_valid rises in the cycle after the beat that carries the addressed word (beat index addr[6:2]) is taken. rsp_rdata equals that beat.
- R5: Victim choice: the lowest-numbered invalid way of the set when one exists. Otherwise a tree pseudo-LRU choice. In that tree, node n has children 2n+1 and 2n+2, a node bit of 1 steers toward the upper half, and every hit or fill sets the bits on its path to point away from the way it used.
- R6: Every store, hit or miss, produces one write on the write channel with wt_addr = addr & ~3 and wt_data = the store data. Both are held steady until wt_ready.
- R7: A store that hits updates the cached word, so a following load to that word hits and returns the new value.
- R8: A store that misses does not allocate, so a following load to that line misses.
- R9: A back-invalidate whose line is resident clears it, so the next load to that line misses. Lines it does not name keep hitting.
- R10: A back-invalidate naming the line being filled, in any cycle from the missing load's acceptance to the last beat, leaves that line invalid after the fill. The load still receives its word.
- R11: After reset every line is invalid, req_ready is high, and rsp_valid, fill_req_valid and wt_valid are low. req_ready is low while a fill or a write-through is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Cache can accept a request |
| req_we | input | 1 | 1 = store word, 0 = load word |
| req_addr | input | 32 | Byte address (low two bits ignored) |
| req_wdata | input | 32 | Store data |
| rsp_valid | output | 1 | Load data valid (one cycle) |
| rsp_rdata | output | 32 | Load data |
| fill_req_valid | output | 1 | Line fetch request |
| fill_req_ready | input | 1 | Next level takes the fetch request |
| fill_req_addr | output | 32 | Line-aligned fetch address |
| fill_rvalid | input | 1 | Fill beat present |
| fill_rdata | input | 32 | Fill beat data |
| wt_valid | output | 1 | Write-through request |
| wt_ready | input | 1 | Next level takes the write |
| wt_addr | output | 32 | Word-aligned write address |
| wt_data | output | 32 | Write data |
| binv_valid | input | 1 | Back-invalidate from the outer cache |
| binv_addr | input | 32 | Address inside the line to remove |

## Verification
The hardest case to reach from the ports is a back-invalidate that targets the very line whose fill is in flight. The stimulus creates it in two places: in the same cycle the missing load is accepted, and in the middle of the stream of beats. In both cases the addressed word lies before or after the injection point, and a later load must then miss again. Pseudo-LRU eviction is forced by filling every way of one set (including the set of 0xDEADBEEF), touching a chosen subset, and missing once more. The bench's behavioural tree model predicts which tag survives. A long mixed run of loads, stores and back-invalidates over a few aliasing sets keeps the model and the design in step for hit/miss timing and data.

// File: rtl/dc_pkg.sv
package dc_pkg;
    localparam int unsigned ADDR_W     = 32;
    localparam int unsigned WORD_W     = 32;
    localparam int unsigned WORD_BYTES = WORD_W / 8;

    typedef enum logic [1:0] {
        S_IDLE,
        S_FREQ,
        S_FILL,
        S_WT
    } dc_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] data;
    } dc_wt_t;

    function automatic logic [ADDR_W-1:0] word_align(input logic [ADDR_W-1:0] a);
        return {a[ADDR_W-1:2], 2'b00};
    endfunction
endpackage

// File: rtl/dc_tag_match.sv
module dc_tag_match #(
    parameter int unsigned WAYS  = 4,
    parameter int unsigned TAG_W = 19,
    localparam int unsigned LW   = $clog2(WAYS)
) (
    input  logic [WAYS*TAG_W-1:0] row_tags,
    input  logic [WAYS-1:0]       row_valid,
    input  logic [TAG_W-1:0]      tag,
    output logic [WAYS-1:0]       hit_vec,
    output logic                  hit,
    output logic [LW-1:0]         hit_way
);
    for (genvar g = 0; g < WAYS; g++) begin : g_cmp
        assign hit_vec[g] = row_valid[g] && (row_tags[g*TAG_W +: TAG_W] == tag);
    end

    assign hit = |hit_vec;

    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (hit_vec[w]) hit_way = LW'(w);
        end
    end
endmodule

// File: rtl/dc_plru.sv
module dc_plru #(
    parameter int unsigned WAYS = 4,
    parameter int unsigned SETS = 64,
    localparam int unsigned LW    = $clog2(WAYS),
    localparam int unsigned IDX_W = $clog2(SETS),
    localparam int unsigned NODES = WAYS - 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_set,
    input  logic [WAYS-1:0]  valid_row,
    input  logic             touch_en,
    input  logic [IDX_W-1:0] touch_set,
    input  logic [LW-1:0]    touch_way,
    output logic [LW-1:0]    victim
);
    logic [NODES-1:0] tree_q [SETS];

    function automatic logic [LW-1:0] walk(input logic [NODES-1:0] b);
        logic [LW-1:0] w;
        int node;
        w = '0;
        node = 0;
        for (int l = 0; l < LW; l++) begin
            w[LW-1-l] = b[node];
            node = 2*node + 1 + int'(b[node]);
        end
        return w;
    endfunction

    function automatic logic [NODES-1:0] mark(input logic [NODES-1:0] b,
                                              input logic [LW-1:0] w);
        logic [NODES-1:0] r;
        int node;
        r = b;
        node = 0;
        for (int l = 0; l < LW; l++) begin
            r[node] = ~w[LW-1-l];
            node = 2*node + 1 + int'(w[LW-1-l]);
        end
        return r;
    endfunction

    always_comb begin
        victim = walk(tree_q[rd_set]);
        for (int w = WAYS-1; w >= 0; w--) begin
            if (!valid_row[w]) victim = LW'(w);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) tree_q[s] <= '0;
        end else if (touch_en) begin
            tree_q[touch_set] <= mark(tree_q[touch_set], touch_way);
        end
    end

    // R5
    invalid_first_chk: assert property (@(posedge clk) disable iff (rst)
        (!(&valid_row)) |-> !valid_row[victim]);
endmodule

// File: rtl/wt_dcache.sv
module wt_dcache
    import dc_pkg::*;
#(
    parameter int unsigned TOTAL_BYTES = 32768,
    parameter int unsigned WAYS        = 4,
    parameter int unsigned LINE_BYTES  = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_we,
    input  logic [31:0]       req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic              fill_req_valid,
    input  logic              fill_req_ready,
    output logic [31:0]       fill_req_addr,
    input  logic              fill_rvalid,
    input  logic [31:0]       fill_rdata,
    output logic              wt_valid,
    input  logic              wt_ready,
    output logic [31:0]       wt_addr,
    output logic [31:0]       wt_data,
    input  logic              binv_valid,
    input  logic [31:0]       binv_addr
);
    localparam int unsigned WAY_BYTES = TOTAL_BYTES / WAYS;
    localparam int unsigned SETS      = WAY_BYTES / LINE_BYTES;
    localparam int unsigned OFF_W     = $clog2(LINE_BYTES);
    localparam int unsigned IDX_W     = $clog2(SETS);
    localparam int unsigned TAG_W     = ADDR_W - OFF_W - IDX_W;
    localparam int unsigned WORDS     = LINE_BYTES / WORD_BYTES;
    localparam int unsigned WOFF_W    = $clog2(WORDS);
    localparam int unsigned LW        = $clog2(WAYS);
    localparam int unsigned LINE_BITS = LINE_BYTES * 8;
    localparam int unsigned WB        = $clog2(WORD_W);
    localparam int unsigned BP_W      = $clog2(LINE_BITS);

    // storage
    logic [WAYS-1:0]       valid_q [SETS];
    logic [WAYS*TAG_W-1:0] tag_q   [SETS];
    logic [LINE_BITS-1:0]  data_q  [SETS*WAYS];

    dc_state_e             state_q;
    logic [IDX_W-1:0]      fl_set_q;
    logic [TAG_W-1:0]      fl_tag_q;
    logic [LW-1:0]         fl_way_q;
    logic [WOFF_W-1:0]     fl_word_q;
    logic [WOFF_W-1:0]     beat_q;
    logic                  pend_q;
    dc_wt_t                wt_q;
    logic                  rsp_valid_q;
    logic [WORD_W-1:0]     rsp_data_q;

    // request address fields
    logic [IDX_W-1:0]  rq_set;
    logic [TAG_W-1:0]  rq_tag;
    logic [WOFF_W-1:0] rq_word;
    logic [BP_W-1:0]   rq_bit;
    logic [BP_W-1:0]   fl_bit;
    assign rq_set  = req_addr[OFF_W +: IDX_W];
    assign rq_tag  = req_addr[ADDR_W-1 -: TAG_W];
    assign rq_word = req_addr[OFF_W-1:2];
    assign rq_bit  = {rq_word, {WB{1'b0}}};
    assign fl_bit  = {beat_q, {WB{1'b0}}};

    logic [IDX_W-1:0] bv_set;
    logic [TAG_W-1:0] bv_tag;
    assign bv_set = binv_addr[OFF_W +: IDX_W];
    assign bv_tag = binv_addr[ADDR_W-1 -: TAG_W];

    logic unused_addr_bits;
    assign unused_addr_bits = ^{req_addr[1:0], binv_addr[OFF_W-1:0]};

    // parallel lookups
    logic [WAYS-1:0] lk_vec, bv_vec;
    logic            lk_hit, bv_hit;
    logic [LW-1:0]   lk_way, bv_way, victim;

    dc_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_req_match (
        .row_tags (tag_q[rq_set]),
        .row_valid(valid_q[rq_set]),
        .tag      (rq_tag),
        .hit_vec  (lk_vec),
        .hit      (lk_hit),
        .hit_way  (lk_way)
    );

    dc_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_binv_match (
        .row_tags (tag_q[bv_set]),
        .row_valid(valid_q[bv_set]),
        .tag      (bv_tag),
        .hit_vec  (bv_vec),
        .hit      (bv_hit),
        .hit_way  (bv_way)
    );

    logic accept, touch_en;
    logic [LW-1:0] touch_way;
    assign req_ready = (state_q == S_IDLE);
    assign accept    = req_valid && req_ready;
    assign touch_en  = accept && (lk_hit || !req_we);
    assign touch_way = lk_hit ? lk_way : victim;

    dc_plru #(.WAYS(WAYS), .SETS(SETS)) u_plru (
        .clk      (clk),
        .rst      (rst),
        .rd_set   (rq_set),
        .valid_row(valid_q[rq_set]),
        .touch_en (touch_en),
        .touch_set(rq_set),
        .touch_way(touch_way),
        .victim   (victim)
    );

    // back-invalidate aimed at the line under fill
    logic fill_busy, binv_on_fill, binv_on_alloc, last_beat;
    assign fill_busy     = (state_q == S_FREQ) || (state_q == S_FILL);
    assign binv_on_fill  = binv_valid && fill_busy &&
                           (binv_addr[ADDR_W-1:OFF_W] == {fl_tag_q, fl_set_q});
    assign binv_on_alloc = binv_valid &&
                           (binv_addr[ADDR_W-1:OFF_W] == req_addr[ADDR_W-1:OFF_W]);
    assign last_beat     = fill_rvalid && (beat_q == WOFF_W'(WORDS-1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= S_IDLE;
            rsp_valid_q <= 1'b0;
            rsp_data_q  <= '0;
            pend_q      <= 1'b0;
            beat_q      <= '0;
            fl_set_q    <= '0;
            fl_tag_q    <= '0;
            fl_way_q    <= '0;
            fl_word_q   <= '0;
            wt_q        <= '0;
            for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
        end else begin
            rsp_valid_q <= 1'b0;
            // resident line removal; a line under fill is never valid here
            if (binv_valid && bv_hit) valid_q[bv_set][bv_way] <= 1'b0;
            case (state_q)
                S_IDLE: begin
                    if (accept) begin
                        if (req_we) begin
                            wt_q.addr <= word_align(req_addr);
                            wt_q.data <= req_wdata;
                            state_q   <= S_WT;
                            if (lk_hit)
                                data_q[{rq_set, lk_way}][rq_bit +: WORD_W] <= req_wdata;
                        end else if (lk_hit) begin
                            rsp_valid_q <= 1'b1;
                            rsp_data_q  <= data_q[{rq_set, lk_way}][rq_bit +: WORD_W];
                        end else begin
                            valid_q[rq_set][victim] <= 1'b0;
                            tag_q[rq_set][int'(victim)*TAG_W +: TAG_W] <= rq_tag;
                            fl_set_q  <= rq_set;
                            fl_tag_q  <= rq_tag;
                            fl_way_q  <= victim;
                            fl_word_q <= rq_word;
                            beat_q    <= '0;
                            pend_q    <= binv_on_alloc;
                            state_q   <= S_FREQ;
                        end
                    end
                end
                S_FREQ: begin
                    if (binv_on_fill) pend_q <= 1'b1;
                    if (fill_req_ready) state_q <= S_FILL;
                end
                S_FILL: begin
                    if (fill_rvalid) begin
                        data_q[{fl_set_q, fl_way_q}][fl_bit +: WORD_W] <= fill_rdata;
                        beat_q <= beat_q + 1'b1;
                        if (beat_q == fl_word_q) begin
                            rsp_valid_q <= 1'b1;
                            rsp_data_q  <= fill_rdata;
                        end
                    end
                    if (last_beat) begin
                        valid_q[fl_set_q][fl_way_q] <= !(pend_q || binv_on_fill);
                        pend_q  <= 1'b0;
                        state_q <= S_IDLE;
                    end else if (binv_on_fill) begin
                        pend_q <= 1'b1;
                    end
                end
                S_WT: begin
                    if (wt_ready) state_q <= S_IDLE;
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    assign rsp_valid      = rsp_valid_q;
    assign rsp_rdata      = rsp_data_q;
    assign fill_req_valid = (state_q == S_FREQ);
    assign fill_req_addr  = {fl_tag_q, fl_set_q, {OFF_W{1'b0}}};
    assign wt_valid       = (state_q == S_WT);
    assign wt_addr        = wt_q.addr;
    assign wt_data        = wt_q.data;

    // R3
    fill_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (fill_req_valid && !fill_req_ready) |=> (fill_req_valid && $stable(fill_req_addr)));

    // R6
    wt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wt_valid && !wt_ready) |=> (wt_valid && $stable(wt_addr) && $stable(wt_data)));

    // R4
    rsp_source_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> ($past(req_valid && req_ready && !req_we) || $past(fill_rvalid)));

    // R2
    single_hit_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lk_vec) && $onehot0(bv_vec));
endmodule

// File: tb/tb_wt_dcache.sv
module tb_wt_dcache;
    localparam int CLK_PERIOD = 10;
    localparam int SETS  = 64;
    localparam int WAYS  = 4;
    localparam int WORDS = 32;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_we;
    logic [31:0] req_addr, req_wdata;
    logic        req_ready, rsp_valid;
    logic [31:0] rsp_rdata;
    logic        fill_req_valid, fill_req_ready, fill_rvalid;
    logic [31:0] fill_req_addr, fill_rdata;
    logic        wt_valid, wt_ready;
    logic [31:0] wt_addr, wt_data;
    logic        binv_valid;
    logic [31:0] binv_addr;

    always #(CLK_PERIOD/2) clk = ~clk;

    wt_dcache dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .fill_req_valid(fill_req_valid), .fill_req_ready(fill_req_ready),
        .fill_req_addr(fill_req_addr),
        .fill_rvalid(fill_rvalid), .fill_rdata(fill_rdata),
        .wt_valid(wt_valid), .wt_ready(wt_ready), .wt_addr(wt_addr), .wt_data(wt_data),
        .binv_valid(binv_valid), .binv_addr(binv_addr)
    );

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    // next-level memory model
    logic [31:0] bmem [int unsigned];
    function automatic logic [31:0] bword(input logic [31:0] a);
        if (bmem.exists(a)) return bmem[a];
        return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
    endfunction

    int          nfills = 0, nwt = 0, beats_given = 0, beat_next = 0;
    bit          fill_active = 0, stall_done = 0;
    logic [31:0] fill_base, last_fill_addr, last_wt_addr, last_wt_data;
    int          cyc = 0;

    initial forever begin
        @(posedge clk);
        if (fill_req_valid && fill_req_ready) begin
            nfills++;
            last_fill_addr = fill_req_addr;
            fill_base = fill_req_addr;
            fill_active = 1; beat_next = 0; beats_given = 0; stall_done = 0;
        end
        if (fill_rvalid) beats_given++;
        if (wt_valid && wt_ready) begin
            nwt++;
            last_wt_addr = wt_addr;
            last_wt_data = wt_data;
            bmem[wt_addr] = wt_data;
        end
    end

    initial begin
        fill_rvalid = 0; fill_rdata = '0; fill_req_ready = 0; wt_ready = 0;
        forever begin
            @(negedge clk);
            cyc++;
            fill_rvalid = 0;
            fill_req_ready = cyc[0];
            wt_ready = (cyc % 3) == 0;
            if (fill_active) begin
                if (beat_next >= WORDS) fill_active = 0;
                else if (beat_next == 7 && !stall_done) stall_done = 1;
                else begin
                    fill_rvalid = 1;
                    fill_rdata = bword(fill_base + 32'(4*beat_next));
                    beat_next++;
                end
            end
        end
    end

    // behavioural reference: tags, valids, tree bits
    int unsigned mtag [SETS][WAYS];
    bit          mval [SETS][WAYS];
    bit          mtree[SETS][WAYS-1];

    function automatic int mset(input logic [31:0] a); return int'((a & 32'h1FFF) >> 7); endfunction
    function automatic int unsigned mtg(input logic [31:0] a); return a >> 13; endfunction

    function automatic int mfind(input logic [31:0] a);
        for (int w = 0; w < WAYS; w++)
            if (mval[mset(a)][w] && mtag[mset(a)][w] == mtg(a)) return w;
        return -1;
    endfunction

    function automatic int mvictim(input int s);
        int node = 0, w = 0, b;
        for (int w2 = 0; w2 < WAYS; w2++) if (!mval[s][w2]) return w2;
        for (int l = 0; l < 2; l++) begin
            b = mtree[s][node];
            w = w*2 + b;
            node = 2*node + 1 + b;
        end
        return w;
    endfunction

    task automatic mtouch(input int s, input int w);
        int node = 0, dir;
        for (int l = 0; l < 2; l++) begin
            dir = (w >> (1-l)) & 1;
            mtree[s][node] = !dir;
            node = 2*node + 1 + dir;
        end
    endtask

    bit rsp_window = 0;
    initial forever begin
        @(negedge clk);
        if (!rst) begin
            if (rsp_valid && !rsp_window)
                chk(0, "R2", "response with no load outstanding", 1, 0);
            if (req_ready && (fill_req_valid || wt_valid))
                chk(0, "R11", "ready while busy", 1, 0);
        end
    end

    task automatic wait_idle();
        int n = 0;
        while (!req_ready && n < 400) begin @(negedge clk); n++; end
    endtask

    // inj: 0 none, 1 back-invalidate in the accept cycle, 2 back-invalidate mid-fill
    task automatic do_load(input logic [31:0] a, input string rq, input int inj);
        int hw, f0, n, rec_n, bat;
        bit got, exp_hit, injected;
        logic [31:0] d, wa;
        wa = a & ~32'h3;
        hw = mfind(a);
        exp_hit = (hw >= 0);
        f0 = nfills;
        got = 0; injected = 0; rec_n = -1; bat = -1; d = '0;
        @(negedge clk);
        req_valid = 1; req_we = 0; req_addr = a;
        if (inj == 1) begin binv_valid = 1; binv_addr = a; end
        rsp_window = 1;
        @(negedge clk);
        req_valid = 0; binv_valid = 0;
        n = 0;
        while (n < 400 && !(got && req_ready)) begin
            if (rsp_valid) begin
                if (got) chk(0, rq, "second response", 1, 0);
                got = 1; rec_n = n; d = rsp_rdata; bat = beats_given;
            end
            if (inj == 2 && !injected && beats_given == 10) begin
                binv_valid = 1; binv_addr = a; injected = 1;
            end else binv_valid = 0;
            if (!(got && req_ready)) begin @(negedge clk); n++; end
        end
        binv_valid = 0;
        rsp_window = 0;
        chk(got, rq, "response seen", 32'(got), 1);
        chk(d == bword(wa), rq, "load data", d, bword(wa));
        if (exp_hit) begin
            chk(rec_n == 0, "R2", "hit latency", 32'(rec_n), 0);
            chk(nfills == f0, "R2", "no fill on hit", 32'(nfills - f0), 0);
            mtouch(mset(a), hw);
        end else begin
            chk(nfills == f0 + 1, rq, "one fill on miss", 32'(nfills - f0), 1);
            chk(last_fill_addr == (a & ~32'h7F), "R3", "fill line address",
                last_fill_addr, a & ~32'h7F);
            chk(bat == int'((a >> 2) & 31) + 1, "R4", "critical word beat",
                32'(bat), 32'(((a >> 2) & 31) + 1));
            hw = mvictim(mset(a));
            mtag[mset(a)][hw] = mtg(a);
            mval[mset(a)][hw] = (inj == 0);
            mtouch(mset(a), hw);
        end
    endtask

    task automatic do_store(input logic [31:0] a, input logic [31:0] v, input string rq);
        int hw, w0;
        hw = mfind(a);
        w0 = nwt;
        @(negedge clk);
        req_valid = 1; req_we = 1; req_addr = a; req_wdata = v;
        @(negedge clk);
        req_valid = 0; req_we = 0;
        wait_idle();
        chk(nwt == w0 + 1, "R6", "one write-through", 32'(nwt - w0), 1);
        chk(last_wt_addr == (a & ~32'h3), "R6", "write address", last_wt_addr, a & ~32'h3);
        chk(last_wt_data == v, rq, "write data", last_wt_data, v);
        if (hw >= 0) mtouch(mset(a), hw);
    endtask

    task automatic do_binv(input logic [31:0] a);
        int hw;
        hw = mfind(a);
        @(negedge clk);
        binv_valid = 1; binv_addr = a;
        @(negedge clk);
        binv_valid = 0;
        if (hw >= 0) mval[mset(a)][hw] = 0;
    endtask

    function automatic logic [31:0] mk(input int tag, input int set, input int word);
        return (32'(tag) << 13) | (32'(set) << 7) | (32'(word) << 2);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        chk(0, "R11", "watchdog expired", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int f0;
        rst = 1; req_valid = 0; req_we = 0; req_addr = '0; req_wdata = '0;
        binv_valid = 0; binv_addr = '0;
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) begin
                mval[s][w] = 0; mtag[s][w] = 0;
                if (w < WAYS-1) mtree[s][w] = 0;
            end
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(req_ready == 1, "R11", "reset req_ready", 32'(req_ready), 1);
        chk(rsp_valid == 0, "R11", "reset rsp_valid", 32'(rsp_valid), 0);
        chk(fill_req_valid == 0, "R11", "reset fill_req_valid", 32'(fill_req_valid), 0);
        chk(wt_valid == 0, "R11", "reset wt_valid", 32'(wt_valid), 0);

        // R1: example address, then fill its set to force eviction
        do_load(32'hDEADBEEF, "R1", 0);
        chk(last_fill_addr == 32'hDEADBE80, "R1", "example line", last_fill_addr, 32'hDEADBE80);
        do_load(32'hDEADBE84, "R1", 0);
        for (int t = 1; t <= 4; t++) do_load(mk(t, 'h3D, 3), "R1", 0);
        do_load(32'hDEADBEEF, "R1", 0);
        do_load(mk(9, 'h3C, 0), "R1", 0);

        // R5: fill a set, touch some ways, force replacement
        for (int t = 1; t <= 4; t++) do_load(mk(t, 5, t), "R5", 0);
        do_load(mk(1, 5, 0), "R5", 0);
        do_load(mk(3, 5, 0), "R5", 0);
        do_load(mk(5, 5, 0), "R5", 0);
        chk(mfind(mk(2, 5, 0)) < 0, "R5", "model evicts way of tag 2", 0, 0);
        do_load(mk(4, 5, 9), "R5", 0);
        do_load(mk(2, 5, 0), "R5", 0);

        // R7: store hit then load hit
        do_load(mk(7, 12, 0), "R7", 0);
        do_store(mk(7, 12, 6), 32'hC0FFEE01, "R7");
        f0 = nfills;
        do_load(mk(7, 12, 6), "R7", 0);
        chk(nfills == f0, "R7", "load after store hit stays a hit", 32'(nfills - f0), 0);

        // R8: store miss, no allocation
        do_store(mk(8, 13, 2), 32'h1234ABCD, "R8");
        f0 = nfills;
        do_load(mk(8, 13, 2), "R8", 0);
        chk(nfills == f0 + 1, "R8", "load after store miss fetches", 32'(nfills - f0), 1);

        // R9: back-invalidate resident / absent lines
        do_load(mk(3, 20, 1), "R9", 0);
        do_load(mk(4, 21, 1), "R9", 0);
        do_binv(mk(3, 20, 30));
        do_binv(mk(6, 21, 0));
        f0 = nfills;
        do_load(mk(3, 20, 1), "R9", 0);
        chk(nfills == f0 + 1, "R9", "invalidated line misses", 32'(nfills - f0), 1);
        f0 = nfills;
        do_load(mk(4, 21, 1), "R9", 0);
        chk(nfills == f0, "R9", "unrelated line still hits", 32'(nfills - f0), 0);

        // R10: back-invalidate against the line under fill
        do_load(mk(11, 30, 25), "R10", 2);
        f0 = nfills;
        do_load(mk(11, 30, 25), "R10", 0);
        chk(nfills == f0 + 1, "R10", "mid-fill invalidate leaves line invalid", 32'(nfills - f0), 1);
        do_load(mk(12, 31, 2), "R10", 2);
        do_load(mk(13, 32, 4), "R10", 1);
        f0 = nfills;
        do_load(mk(12, 31, 2), "R10", 0);
        do_load(mk(13, 32, 4), "R10", 0);
        chk(nfills == f0 + 2, "R10", "both lines refetched", 32'(nfills - f0), 2);

        // mixed traffic over aliasing sets
        for (int i = 0; i < 250; i++) begin
            int op, st, tg, wd;
            logic [31:0] a;
            op = int'($urandom_range(0, 19));
            st = (i % 3 == 0) ? 'h3D : ((i % 3 == 1) ? 2 : 9);
            tg = int'($urandom_range(0, 5));
            wd = int'($urandom_range(0, 31));
            a  = mk(tg, st, wd);
            if (op < 12) do_load(a, "R5", 0);
            else if (op < 17) do_store(a, $urandom, "R6");
            else do_binv(a);
        end

        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule